// File: doc/BRIEF.md
# Floating-Point Multiply-Accumulate Unit with Register Bus

This block is a multiply-accumulate engine that sits on a simple synchronous register bus. It works on a 32-bit floating-point format of its own. Bit 31 is the sign, and a 1 there means positive. Bits 30:23 hold an exponent with a bias of 128. Bits 22:0 hold a mantissa with an implied leading one, so a word encodes (sign) 1.m × 2^(exp−128). A word whose bits 30:0 are all zero is zero, whatever its sign bit. The block writes zero back as 0x80000000. A magnitude too large to encode saturates to 0xFFFFFFFF when positive and to 0x7FFFFFFF when negative.

The host first loads a multiplier constant. Each word it then writes to the stream address starts one operation: the accumulator becomes constant × stream + accumulator. One cycle of `busy` follows the write, then one cycle of `mac_done`. The host reads the accumulator at the result address. A write of any value to the clear address sets the accumulator to zero and pulses `clr_done`. Clearing and accumulating are independent commands, each with its own done pulse. Both the multiply and the add truncate their results.

Top module: `fpmac_unit`

## Requirements
- R1: After reset, `busy`, `mac_done` and `clr_done` are low, and both the accumulator and the constant read back as 0x80000000.
- R2: An operand whose bits 30:0 are zero is treated as zero, for either sign bit. Zero times anything leaves the accumulator unchanged.
- R3: The product sign is the XNOR of the operand signs, with 1 meaning positive. The product mantissa is truncated, not rounded: (1+2^−23)² gives 0xC0000002.
- R4: A stream write (address 0x803000) seen while idle makes `busy` high for exactly the next cycle. `mac_done` is high for exactly the cycle after that, and the accumulator already holds the new value in that cycle.
- R5: Each operation sets the accumulator to constant × stream + accumulator. Outside an operation or a clear, the accumulator does not change. Reading address 0x804000 returns the accumulator.
- R6: A stream write seen while `busy` is high is ignored. It starts no operation and does not change the result.
- R7: A write of any value to address 0x801000 sets the accumulator to 0x80000000. `clr_done` is high for exactly the following cycle.
- R8: A clear written during the `busy` cycle wins over the pending accumulator update. The accumulator reads 0x80000000 when `mac_done` and `clr_done` rise together.
- R9: Results whose exponent would pass 255 saturate to 0xFFFFFFFF if positive and to 0x7FFFFFFF if negative. This holds for both the product and the sum.
- R10: Results whose exponent would fall below 0, and sums that cancel exactly, produce 0x80000000.
- R11: Reading address 0x802000 returns the constant. Reading any address other than 0x802000 and 0x804000 returns 0.
- R12: A write to address 0x802000 replaces the constant, and every later operation uses the new constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| busy | output | 1 | Operation in flight |
| mac_done | output | 1 | One-cycle pulse when an operation completes |
| clr_done | output | 1 | One-cycle pulse after a clear |

## Verification
A sweep of constants and stream words runs through a long accumulation chain. The values are chosen so the exact sums are representable, and the bench computes them in real arithmetic. A wrong alignment or normalisation shift, or a wrong sign choice on subtraction, would give wrong sums in that chain. Directed cases cover product and sum overflow, underflow of tiny × tiny, and exact cancellation. A design that wrapped the exponent instead of saturating or flushing to zero would return unrelated large or tiny words in those cases. Further cases cover a stream write that lands in the busy cycle, and a clear that lands in the busy cycle. A design that re-triggered would accumulate twice, and one that let the update win would leave a non-zero accumulator after the clear.

// File: rtl/fpmac_unit.sv
module fpmac_unit #(
  parameter logic [23:0] A_CLR    = 24'h801000,
  parameter logic [23:0] A_CONST  = 24'h802000,
  parameter logic [23:0] A_STREAM = 24'h803000,
  parameter logic [23:0] A_RESULT = 24'h804000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic        mac_done,
  output logic        clr_done
);
  localparam logic [31:0] ZERO    = 32'h8000_0000;
  localparam logic [31:0] POS_MAX = 32'hFFFF_FFFF;
  localparam logic [31:0] NEG_MAX = 32'h7FFF_FFFF;

  function automatic logic [31:0] pack(input logic s, input logic signed [10:0] e,
                                       input logic [22:0] m);
    if (e > 11'sd255)    return s ? POS_MAX : NEG_MAX;
    else if (e < 11'sd0) return ZERO;
    else                 return {s, e[7:0], m};
  endfunction

  function automatic logic [31:0] fmul(input logic [31:0] a, input logic [31:0] b);
    logic [47:0] p;
    logic signed [10:0] e;
    logic [22:0] m;
    if (a[30:0] == 31'd0 || b[30:0] == 31'd0) return ZERO;
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = $signed({3'b000, a[30:23]}) + $signed({3'b000, b[30:23]}) - 11'sd128;
    if (p[47]) begin
      e = e + 11'sd1;
      m = p[46:24];
    end else begin
      m = p[45:23];
    end
    return pack(a[31] ~^ b[31], e, m);
  endfunction

  function automatic logic [31:0] fadd(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] x, y;
    logic [7:0]  d;
    logic [24:0] mx, my, sum;
    logic [4:0]  sh;
    logic signed [10:0] e;
    logic [22:0] m;
    if (a[30:0] == 31'd0) return (b[30:0] == 31'd0) ? ZERO : b;
    if (b[30:0] == 31'd0) return a;
    if (a[30:0] >= b[30:0]) begin x = a; y = b; end
    else                    begin x = b; y = a; end
    d  = x[30:23] - y[30:23];
    mx = {2'b01, x[22:0]};
    my = {2'b01, y[22:0]} >> d;
    e  = $signed({3'b000, x[30:23]});
    if (x[31] == y[31]) begin
      sum = mx + my;
      if (sum[24]) begin
        e = e + 11'sd1;
        m = sum[23:1];
      end else begin
        m = sum[22:0];
      end
    end else begin
      sum = mx - my;
      if (sum == 25'd0) return ZERO;
      sh = 5'd0;
      for (int i = 0; i < 24; i++)
        if (sum[i]) sh = 5'(23 - i);
      sum = sum << sh;
      e = e - $signed({6'b000000, sh});
      m = sum[22:0];
    end
    return pack(x[31], e, m);
  endfunction

  logic [31:0] const_q, acc_q, prod_q;
  logic        busy_q, done_q, cdone_q;

  wire wr_clr    = bus_wr && (bus_addr == A_CLR);
  wire wr_const  = bus_wr && (bus_addr == A_CONST);
  wire wr_stream = bus_wr && (bus_addr == A_STREAM);
  wire start     = wr_stream && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      const_q <= ZERO;
      acc_q   <= ZERO;
      prod_q  <= ZERO;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cdone_q <= 1'b0;
    end else begin
      busy_q  <= start;
      done_q  <= busy_q;
      cdone_q <= wr_clr;
      if (wr_const) const_q <= bus_wdata;
      if (start)    prod_q  <= fmul(const_q, bus_wdata);
      if (wr_clr)      acc_q <= ZERO;
      else if (busy_q) acc_q <= fadd(acc_q, prod_q);
    end
  end

  assign bus_rdata = (bus_addr == A_RESULT) ? acc_q :
                     (bus_addr == A_CONST)  ? const_q : 32'd0;
  assign busy     = busy_q;
  assign mac_done = done_q;
  assign clr_done = cdone_q;
endmodule

// File: rtl/fpmac_unit_chk.sv
module fpmac_unit_chk #(
  parameter logic [23:0] A_CLR    = 24'h801000,
  parameter logic [23:0] A_CONST  = 24'h802000,
  parameter logic [23:0] A_STREAM = 24'h803000,
  parameter logic [23:0] A_RESULT = 24'h804000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic        mac_done,
  input logic        clr_done,
  input logic [31:0] acc
);
  wire stream_wr = bus_wr && bus_addr == A_STREAM;
  wire clear_wr  = bus_wr && bus_addr == A_CLR;
  wire unmapped  = bus_addr != A_CONST && bus_addr != A_RESULT;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy); // R4
  AST_DONE_FOLLOWS:   assert property (@(posedge clk) disable iff (!rst_n) busy |=> mac_done); // R4
  AST_DONE_CAUSE:     assert property (@(posedge clk) disable iff (!rst_n) mac_done |-> $past(busy)); // R4
  AST_START:          assert property (@(posedge clk) disable iff (!rst_n) (stream_wr && !busy) |=> busy); // R4
  AST_IGNORE_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (stream_wr && busy) |=> !busy); // R6
  AST_ACC_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (!busy && !clear_wr) |=> $stable(acc)); // R5
  AST_CLEAR_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) clr_done |-> acc == 32'h8000_0000); // R7
  AST_CLEAR_WINS:     assert property (@(posedge clk) disable iff (!rst_n) (busy && clear_wr) |=> acc == 32'h8000_0000); // R8
  AST_UNMAPPED_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) unmapped |-> bus_rdata == 32'd0); // R11
endmodule

bind fpmac_unit fpmac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .busy(busy), .mac_done(mac_done),
  .clr_done(clr_done), .acc(acc_q)
);

// File: tb/fpmac_unit_bench.sv
`timescale 1ns/1ps
module fpmac_unit_bench;
  localparam logic [23:0] A_CLR    = 24'h801000;
  localparam logic [23:0] A_CONST  = 24'h802000;
  localparam logic [23:0] A_STREAM = 24'h803000;
  localparam logic [23:0] A_RESULT = 24'h804000;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [23:0] bus_addr = 24'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic busy, mac_done, clr_done;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fpmac_unit u_fpmac_unit (.*);

  function automatic logic [31:0] to_fmt(input real r);
    real a;
    int e;
    if (r == 0.0) return 32'h8000_0000;
    a = (r < 0.0) ? -r : r;
    e = 0;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    return {r > 0.0, 8'(e + 128), 23'($rtoi((a - 1.0) * 8388608.0))};
  endfunction

  function automatic real from_fmt(input logic [31:0] w);
    real v;
    if (w[30:0] == 31'd0) return 0.0;
    v = (1.0 + $itor(w[22:0]) / 8388608.0) * (2.0 ** ($itor(w[30:23]) - 128.0));
    return w[31] ? v : -v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 24'd0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 24'd0;
  endtask

  task automatic mac(input logic [31:0] s);
    wr(A_STREAM, s);
    check("R4 busy after start", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R4 done pulse", {30'd0, busy, mac_done}, 32'd1);
  endtask

  task automatic expect_acc(input string tag, input logic [31:0] exp);
    logic [31:0] r;
    rd(A_RESULT, r);
    check(tag, r, exp);
  endtask

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    real accr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", {29'd0, busy, mac_done, clr_done}, 32'd0);
    expect_acc("R1 accumulator", 32'h8000_0000);
    rd(A_CONST, r); check("R1 constant", r, 32'h8000_0000);

    // near-exhaustive sweep, exact values
    accr = 0.0;
    for (int k = 0; k < 9; k++) begin
      wr(A_CONST, to_fmt((k - 4) * 0.75));
      rd(A_CONST, r); check("R12 constant readback", r, to_fmt((k - 4) * 0.75));
      for (int j = 0; j < 7; j++) begin
        mac(to_fmt((j - 3) * 0.5));
        accr = accr + (k - 4) * 0.75 * ((j - 3) * 0.5);
        expect_acc("R5 sweep accumulate", to_fmt(accr));
      end
    end

    // worked sequences
    wr(A_CLR, 32'h1234);
    wr(A_CONST, to_fmt(-30.0)); mac(to_fmt(-1.0)); expect_acc("R5 -30*-1", to_fmt(30.0));
    wr(A_CONST, to_fmt(1.0));   mac(to_fmt(-1.0)); expect_acc("R5 1*-1+30", to_fmt(29.0));
    wr(A_CLR, 32'd0);
    check("R7 clr_done pulse", {31'd0, clr_done}, 32'd1);
    @(negedge clk);
    check("R7 clr_done falls", {31'd0, clr_done}, 32'd0);
    expect_acc("R7 cleared", 32'h8000_0000);
    wr(A_CONST, to_fmt(5.0));
    mac(to_fmt(1.0));  expect_acc("R5 1*5", to_fmt(5.0));
    mac(to_fmt(7.0));  expect_acc("R5 7*5+5", to_fmt(40.0));
    mac(to_fmt(-5.0)); expect_acc("R5 -5*5+40", to_fmt(15.0));
    wr(A_CONST, to_fmt(7.45)); mac(to_fmt(-5.0));
    rd(A_RESULT, r);
    checks++;
    if (from_fmt(r) > -22.2499 || from_fmt(r) < -22.2501) begin
      errors++;
      $display("FAIL R5 -5*7.45+15 got %h expected about %h", r, to_fmt(-22.25));
    end

    // R3 sign and truncation
    wr(A_CLR, 32'd0);
    wr(A_CONST, to_fmt(-2.0)); mac(to_fmt(-3.0)); expect_acc("R3 sign xnor", to_fmt(6.0));
    wr(A_CLR, 32'd0);
    wr(A_CONST, 32'hC000_0001); mac(32'hC000_0001); expect_acc("R3 truncation", 32'hC000_0002);

    // R9 saturation
    wr(A_CLR, 32'd0);
    wr(A_CONST, 32'hFFFF_FFFF); mac(to_fmt(2.0)); expect_acc("R9 product pos sat", 32'hFFFF_FFFF);
    wr(A_CLR, 32'd0);
    wr(A_CONST, 32'h7FFF_FFFF); mac(to_fmt(2.0)); expect_acc("R9 product neg sat", 32'h7FFF_FFFF);
    wr(A_CLR, 32'd0);
    wr(A_CONST, to_fmt(1.0));
    mac(32'hFFFF_FFFF); mac(32'hFFFF_FFFF); expect_acc("R9 sum pos sat", 32'hFFFF_FFFF);
    wr(A_CLR, 32'd0);
    mac(32'h7FFF_FFFF); mac(32'h7FFF_FFFF); expect_acc("R9 sum neg sat", 32'h7FFF_FFFF);

    // R10 underflow and cancellation
    wr(A_CLR, 32'd0);
    wr(A_CONST, 32'h8000_0001); mac(32'h8000_0001); expect_acc("R10 underflow", 32'h8000_0000);
    wr(A_CONST, to_fmt(3.0));
    mac(to_fmt(1.0)); mac(to_fmt(-1.0)); expect_acc("R10 cancellation", 32'h8000_0000);

    // R2 zero operands of either sign
    mac(to_fmt(1.0));
    wr(A_CONST, 32'h0000_0000); mac(to_fmt(5.0)); expect_acc("R2 negative zero const", to_fmt(3.0));
    wr(A_CONST, to_fmt(4.0));   mac(32'h8000_0000); expect_acc("R2 positive zero stream", to_fmt(3.0));

    // R6 stream write during busy
    wr(A_CLR, 32'd0);
    wr(A_CONST, to_fmt(2.0));
    @(negedge clk);
    bus_addr = A_STREAM; bus_wdata = to_fmt(1.0); bus_wr = 1'b1;
    @(negedge clk);
    check("R6 busy seen", {31'd0, busy}, 32'd1);
    bus_wdata = to_fmt(4.0);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 24'd0;
    check("R6 no restart", {30'd0, busy, mac_done}, 32'd1);
    @(negedge clk);
    check("R6 idle after", {30'd0, busy, mac_done}, 32'd0);
    expect_acc("R6 single accumulate", to_fmt(2.0));

    // R8 clear during busy
    @(negedge clk);
    bus_addr = A_STREAM; bus_wdata = to_fmt(1.0); bus_wr = 1'b1;
    @(negedge clk);
    bus_addr = A_CLR;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 24'd0;
    check("R8 both done", {30'd0, mac_done, clr_done}, 32'd3);
    expect_acc("R8 clear wins", 32'h8000_0000);
    mac(to_fmt(1.0)); expect_acc("R8 fresh start", to_fmt(2.0));

    // R11 read map
    rd(A_CONST, r);     check("R11 constant read", r, to_fmt(2.0));
    rd(24'h805000, r);  check("R11 unmapped", r, 32'd0);
    rd(A_CLR, r);       check("R11 clear address reads zero", r, 32'd0);
    rd(A_STREAM, r);    check("R11 stream address reads zero", r, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule